// File: doc/BRIEF.md
# Two-Channel Wiper Register Controller with I2C Slave Port

This block is an I2C slave that sits in front of three small volatile registers: two 8-bit wiper positions and one control byte that holds an active-low shutdown bit. A host on the two-wire bus writes and reads these registers. The block drives the two wiper-position outputs and a shutdown flag for the analog section beside it, which is outside this block.

The block runs from a fast system clock that oversamples SCL and SDA. Each line passes through a two-flop synchronizer and then a glitch filter, and only after that is it checked for edges, START and STOP. SDA is driven through an open-drain pull enable. A bus transaction is a device-identification byte, then a register-address byte, then one or more data bytes. A read returns to the identification phase through a repeated START.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset both wiper outputs are 80h, `shdn_n` is 1, the control register reads 40h, and SDA is released. A START that occurs while reset is held is ignored, so the bytes after reset get no ACK.
- R2: The identification byte is bits [7:4]=1010, bits [3:1]=`strap[2:0]`, bit 0 = direction (1 read, 0 write). A matching byte is ACKed by pulling SDA low during the ninth clock. A byte that does not match gets no ACK, and the slave leaves SDA released and the registers unchanged until the next START or STOP.
- R3: A write is START, identification byte with direction 0, address byte, data byte. The slave ACKs every byte. The data byte reaches its register on the ninth SCL rising edge of that byte, so the output changes before any STOP.
- R4: Further data bytes sent before STOP go to the next channel. The pointer steps 00h→01h→00h.
- R5: Address 10h is the control register. Only bit 6 is stored and the other bits read as 0. `shdn_n` follows bit 6, and 0 means shutdown. The pointer does not advance at 10h, so every data byte of a burst lands there.
- R6: Entering or leaving shutdown does not change either wiper value. Wiper writes made during shutdown are kept.
- R7: A read is START, identification byte (write), address byte, repeated START, identification byte (read), then data bytes MSB first. The pointer advances with the same wrap as writes. A master NACK ends the read, and SDA stays released afterwards.
- R8: Writes to addresses other than 00h, 01h and 10h are ACKed and discarded. Reads from such addresses return 00h, and the pointer does not move there.
- R9: After a STOP the slave is idle. Bus traffic that is not preceded by a START gets no ACK and changes no register.
- R10: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks (default 5, i.e. 50 ns at 100 MHz) has no effect on the transfer.
- R11: `sda_pull_n` changes only after a falling SCL edge, never while SCL is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| scl_in | input | 1 | Bus clock as seen at the pin |
| sda_in | input | 1 | Bus data as seen at the pin (wired-AND line) |
| strap | input | 3 | Low three bits of the device address |
| sda_pull_n | output | 1 | 0 pulls SDA low, 1 releases it |
| wiper0 | output | 8 | Position of wiper channel 0 |
| wiper1 | output | 8 | Position of wiper channel 1 |
| shdn_n | output | 1 | Shutdown flag, 0 = shutdown |

## Verification
The hardest situation to reach is a bus glitch that arrives in the middle of a live transfer and would, without filtering, be decoded as an extra clock or a false START. The stimulus adds a 40 ns high pulse on SCL inside every low phase of a data byte. It also adds a 40 ns low pulse on SDA while SCL is high on each 1 bit. The check is that the byte is still ACKed and committed unchanged. Repeated START with a preserved pointer, and a START issued while reset is held, are reached by driving the bus sequence directly at the pins.

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave #(
  parameter int          FILT_CYC = 5,
  parameter logic [3:0]  DEV_ID   = 4'b1010,
  parameter logic [7:0]  WIPER_RST = 8'h80
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap,
  output logic       sda_pull_n,
  output logic [7:0] wiper0,
  output logic [7:0] wiper1,
  output logic       shdn_n
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [7:0] A_W0 = 8'h00, A_W1 = 8'h01, A_CTL = 8'h10;

  typedef enum logic [2:0] {S_IDLE, S_ID, S_ADDR, S_WR, S_RD, S_SKIP} st_t;

  logic [1:0] s1, s2, filt, filt_q;
  logic [1:0][FW-1:0] fcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; filt <= 2'b11; filt_q <= 2'b11; fcnt <= '0;
    end else begin
      s1 <= {scl_in, sda_in};
      s2 <= s1;
      filt_q <= filt;
      for (int i = 0; i < 2; i++)
        if (s2[i] == filt[i]) fcnt[i] <= '0;
        else if (fcnt[i] == FW'(FILT_CYC - 1)) begin
          fcnt[i] <= '0;
          filt[i] <= s2[i];
        end else fcnt[i] <= fcnt[i] + 1'b1;
    end

  wire scl_f    = filt[1];
  wire sda_f    = filt[0];
  wire scl_rise = scl_f & ~filt_q[1];
  wire scl_fall = ~scl_f & filt_q[1];
  wire start_c  = scl_f & filt_q[1] & filt_q[0] & ~sda_f;
  wire stop_c   = scl_f & filt_q[1] & ~filt_q[0] & sda_f;

  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] sh, ptr, ptr_nx, rd_byte;
  logic       ctl6;

  wire id_ok = (sh[7:1] == {DEV_ID, strap});
  assign shdn_n = ctl6;

  always_comb
    case (ptr)
      A_W0:    rd_byte = wiper0;
      A_W1:    rd_byte = wiper1;
      A_CTL:   rd_byte = {1'b0, ctl6, 6'b0};
      default: rd_byte = 8'h00;
    endcase

  always_comb
    case (ptr)
      A_W0:    ptr_nx = A_W1;
      A_W1:    ptr_nx = A_W0;
      default: ptr_nx = ptr;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; sh <= '0; ptr <= '0;
      wiper0 <= WIPER_RST; wiper1 <= WIPER_RST; ctl6 <= 1'b1; sda_pull_n <= 1'b1;
    end else if (start_c) begin
      st <= S_ID; bitcnt <= '0; sda_pull_n <= 1'b1;
    end else if (stop_c) begin
      st <= S_IDLE; sda_pull_n <= 1'b1;
    end else if (st != S_IDLE && st != S_SKIP) begin
      if (scl_rise) begin
        if (bitcnt != 4'd8) begin
          sh <= {sh[6:0], sda_f};
          bitcnt <= bitcnt + 1'b1;
        end else begin
          bitcnt <= '0;
          case (st)
            S_ID:   st <= !id_ok ? S_SKIP : (sh[0] ? S_RD : S_ADDR);
            S_ADDR: begin ptr <= sh; st <= S_WR; end
            S_WR: begin
              case (ptr)
                A_W0:    wiper0 <= sh;
                A_W1:    wiper1 <= sh;
                A_CTL:   ctl6 <= sh[6];
                default: ;
              endcase
              ptr <= ptr_nx;
            end
            S_RD:   if (sda_f) st <= S_SKIP; else ptr <= ptr_nx;
            default: ;
          endcase
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) sda_pull_n <= (st == S_RD) | ((st == S_ID) & !id_ok);
        else if (st == S_RD) sda_pull_n <= rd_byte[~bitcnt[2:0]];
        else sda_pull_n <= 1'b1;
      end
    end

  // R11
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && filt_q[1] && !start_c && !stop_c) |=> $stable(sda_pull_n));

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_SKIP) |-> sda_pull_n);

  // R3
  wiper_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper0 != $past(wiper0) || wiper1 != $past(wiper1)) |->
      $past(st == S_WR && scl_rise && bitcnt == 4'd8));

  // R5
  ctl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_n != $past(shdn_n)) |-> $past(st == S_WR && ptr == A_CTL && scl_rise));
endmodule

// File: tb/test_wiper_i2c_slave.sv
module test_wiper_i2c_slave;
  localparam int Q = 20;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] ID_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] ID_R = {4'b1010, STRAP, 1'b1};

  typedef struct packed {
    logic [7:0] a, d, rd, w0, w1;
    logic       sd;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'h00, 8'h3C, 8'h3C, 8'h3C, 8'h80, 1'b1, 4'd3},
    '{8'h01, 8'hFF, 8'hFF, 8'h3C, 8'hFF, 1'b1, 4'd3},
    '{8'h10, 8'hBF, 8'h00, 8'h3C, 8'hFF, 1'b0, 4'd5},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b0, 4'd6},
    '{8'h10, 8'h7F, 8'h40, 8'h00, 8'hFF, 1'b1, 4'd6},
    '{8'h05, 8'hAA, 8'h00, 8'h00, 8'hFF, 1'b1, 4'd8},
    '{8'h01, 8'h5A, 8'h5A, 8'h00, 8'h5A, 1'b1, 4'd7}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_pull_n, shdn_n;
  logic [7:0] wiper0, wiper1;
  wire sda_line = sda_m & sda_pull_n;
  int nchk = 0, nfail = 0, viol = 0, hi_cnt = 0;
  logic prev_pull = 1'b1;

  always #5 clk = ~clk;

  wiper_i2c_slave i_wiper_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .strap(STRAP),
    .sda_pull_n(sda_pull_n), .wiper0(wiper0), .wiper1(wiper1), .shdn_n(shdn_n));

  always @(posedge clk) begin
    hi_cnt <= scl ? hi_cnt + 1 : 0;
    if (rst_n && hi_cnt >= 8 && sda_pull_n !== prev_pull) viol <= viol + 1;
    prev_pull <= sda_pull_n;
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic i2c_start; sda_m = 1; w(Q); scl = 1; w(Q); sda_m = 0; w(Q); scl = 0; w(Q); endtask
  task automatic i2c_stop;  sda_m = 0; w(Q); scl = 1; w(Q); sda_m = 1; w(Q); endtask

  task automatic tx(input logic [7:0] b, input bit gl, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (gl) begin w(6); scl = 1; w(4); scl = 0; w(Q - 10); end else w(Q);
      scl = 1;
      if (gl && b[i]) begin w(6); sda_m = 0; w(4); sda_m = 1; w(Q - 10); end else w(Q);
      scl = 0; w(2);
    end
    sda_m = 1; w(Q); scl = 1; w(Q / 2); ack = (sda_line == 1'b0); w(Q / 2); scl = 0; w(Q);
  endtask

  task automatic rx(input bit more, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl = 1; w(Q / 2); b[i] = sda_line; w(Q / 2); scl = 0; w(2);
    end
    sda_m = ~more; w(Q); scl = 1; w(Q); scl = 0; w(2); sda_m = 1; w(Q);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1,
                    input int n, input bit gl, output bit ok);
    bit k;
    ok = 1;
    i2c_start;
    tx(ID_W, 0, k); ok &= k;
    tx(a, 0, k);    ok &= k;
    tx(d0, gl, k);  ok &= k;
    if (n > 1) begin tx(d1, 0, k); ok &= k; end
  endtask

  task automatic rd(input logic [7:0] a, input int n, output logic [7:0] r0,
                    output logic [7:0] r1, output bit ok);
    bit k;
    ok = 1; r1 = '0;
    i2c_start;
    tx(ID_W, 0, k); ok &= k;
    tx(a, 0, k);    ok &= k;
    i2c_start;
    tx(ID_R, 0, k); ok &= k;
    rx(n > 1, r0);
    if (n > 1) rx(1'b0, r1);
    i2c_stop;
  endtask

  initial begin
    bit ok, k;
    logic [7:0] r0, r1;
    w(5);
    chk("R1 wiper0", wiper0, 8'h80);
    chk("R1 wiper1", wiper1, 8'h80);
    chk("R1 shdn_n", {7'b0, shdn_n}, 8'h01);
    chk("R1 sda", {7'b0, sda_pull_n}, 8'h01);
    rst_n = 1; w(5);
    rd(8'h10, 1, r0, r1, ok);
    chk("R1 ctl read", r0, 8'h40);
    chk("R2 ack", {7'b0, ok}, 8'h01);

    foreach (VECS[i]) begin
      wr(VECS[i].a, VECS[i].d, 8'h00, 1, 0, ok);
      i2c_stop;
      chk($sformatf("R%0d v%0d ack", VECS[i].req, i), {7'b0, ok}, 8'h01);
      rd(VECS[i].a, 1, r0, r1, ok);
      chk($sformatf("R%0d v%0d read", VECS[i].req, i), r0, VECS[i].rd);
      chk($sformatf("R%0d v%0d wiper0", VECS[i].req, i), wiper0, VECS[i].w0);
      chk($sformatf("R%0d v%0d wiper1", VECS[i].req, i), wiper1, VECS[i].w1);
      chk($sformatf("R%0d v%0d shdn_n", VECS[i].req, i), {7'b0, shdn_n}, {7'b0, VECS[i].sd});
    end

    // R3: commit visible before STOP
    wr(8'h00, 8'hC3, 8'h00, 1, 0, ok);
    chk("R3 commit before stop", wiper0, 8'hC3);
    i2c_stop;

    // R4: sequential write wraps 01h -> 00h
    wr(8'h01, 8'h21, 8'h22, 2, 0, ok);
    i2c_stop;
    chk("R4 wiper1", wiper1, 8'h21);
    chk("R4 wiper0", wiper0, 8'h22);

    // R5: burst to 10h stays at 10h
    wr(8'h10, 8'h40, 8'h00, 2, 0, ok);
    i2c_stop;
    chk("R5 burst shdn_n", {7'b0, shdn_n}, 8'h00);
    chk("R6 wiper0 kept", wiper0, 8'h22);
    chk("R6 wiper1 kept", wiper1, 8'h21);
    wr(8'h10, 8'hFF, 8'h00, 1, 0, ok);
    i2c_stop;
    rd(8'h10, 1, r0, r1, ok);
    chk("R5 ctl masked", r0, 8'h40);
    chk("R6 wiper0 after exit", wiper0, 8'h22);

    // R7: sequential read with wrap, then released
    rd(8'h01, 2, r0, r1, ok);
    chk("R7 first", r0, 8'h21);
    chk("R7 second", r1, 8'h22);
    chk("R7 released", {7'b0, sda_pull_n}, 8'h01);

    // R8: unmapped burst discarded
    wr(8'h7F, 8'h11, 8'h12, 2, 0, ok);
    i2c_stop;
    chk("R8 ack", {7'b0, ok}, 8'h01);
    chk("R8 wiper0", wiper0, 8'h22);
    chk("R8 wiper1", wiper1, 8'h21);

    // R2: wrong strap and wrong prefix
    i2c_start;
    tx(8'hA6, 0, k); chk("R2 strap mismatch", {7'b0, k}, 8'h00);
    tx(8'h00, 0, k); chk("R2 ignored addr", {7'b0, k}, 8'h00);
    tx(8'h55, 0, k);
    i2c_stop;
    i2c_start;
    tx(8'hBA, 0, k); chk("R2 prefix mismatch", {7'b0, k}, 8'h00);
    i2c_stop;
    chk("R2 wiper0", wiper0, 8'h22);

    // R9: traffic without START after STOP
    scl = 0; w(Q);
    tx(ID_W, 0, k);  chk("R9 no ack", {7'b0, k}, 8'h00);
    tx(8'h00, 0, k);
    tx(8'h66, 0, k);
    i2c_stop;
    chk("R9 wiper0", wiper0, 8'h22);

    // R10: glitches inside a data byte
    wr(8'h00, 8'hB5, 8'h00, 1, 1, ok);
    i2c_stop;
    chk("R10 ack", {7'b0, ok}, 8'h01);
    chk("R10 wiper0", wiper0, 8'hB5);

    // R11
    chk("R11 sda changes with scl high", viol[7:0], 8'h00);

    // R1: START during reset is ignored
    rst_n = 0; w(3);
    i2c_start;
    rst_n = 1; w(3);
    tx(ID_W, 0, k);
    chk("R1 start in reset ignored", {7'b0, k}, 8'h00);
    i2c_stop;
    chk("R1 wiper0 reset", wiper0, 8'h80);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
    $finish;
  end
endmodule